// File: doc/BRIEF.md
# Key-Guarded Sequencer Configuration Port

This block is a byte-wide register slave that sits in front of a power sequencer. It guards two kinds of configuration. The first is a bank of start-index registers, one for each power transition. The second is the sequencer's script memory. Writes to any guarded register are dropped unless a two-step key has first been written to the key register. Writing to the key register again closes the port.

The script memory is not mapped into the register space. Software writes a byte address to a pointer register, then writes bytes to a data register. Each data write appears on the memory write port for exactly one cycle and advances the pointer by one. A four-byte instruction therefore needs one pointer write followed by four data writes.

A guarded write made while the port is closed sets a sticky violation flag. Software can read this flag and clear it. All outputs are registered.

Top module: `cfgk_port`

## Requirements
- R1: After a synchronous reset the port is locked, the violation flag is 0, every start index is 0x00, the pointer is 0x00 and `mem_we` is 0.
- R2: Writing 0xC0 to the key register (offset 0x0) and then 0x0C as the next bus write unlocks the port. A read of the key register returns 0x01 when unlocked and 0x00 otherwise. After only the first key it still reads 0x00.
- R3: In the armed state, any key value other than 0x0C returns the port to locked. This includes a repeated 0xC0. A write to any other offset between the two key writes also returns the port to locked.
- R4: While unlocked, any write to the key register locks the port. The value 0x00 is the intended lock value.
- R5: While locked, writes to the pointer (0x2), data (0x3) and start-index (0x4 upward) offsets change nothing: the pointer, the start indices and the memory port are all left as they were.
- R6: A guarded write made while locked sets the violation flag, which reads at bit 0 of offset 0x1. The flag stays set until a write to offset 0x1 with bit 0 = 1 clears it. Writes to offset 0x1 are never guarded.
- R7: While unlocked, a data write raises `mem_we` for exactly the one cycle after the write. In that cycle `mem_addr` holds the pointer value and `mem_wdata` holds the written byte.
- R8: Each data write advances the pointer by one, wrapping from 0xFF to 0x00. A read of offset 0x2 returns the pointer.
- R9: While unlocked, a write to offset 0x4+i loads start index i. The value drives `start_idx[8*i +: 8]` and reads back from the same offset.
- R10: A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Unmapped offsets read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mem_we | output | 1 | Script memory write enable |
| mem_addr | output | 8 | Script memory byte address |
| mem_wdata | output | 8 | Script memory write byte |
| start_idx | output | 8*N_START | Start index for each transition |

## Verification
Some properties hold on every cycle, and assertions check them continuously:
- a key write in the open state always relocks the port;
- the port opens only right after the second key value;
- a memory write strobe is only ever preceded by an unlocked cycle, and the pointer sits one beyond the address it puts out;
- the start indices never move while the port is locked;
- the violation flag drops only after a clear write.

Other behaviour depends on ordering and needs the bench's scenarios:
- a wrong or repeated first key, and an interleaved write between the two keys;
- the read-back encodings;
- pointer wrap at 0xFF;
- reset in the middle of a run.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_KEY   = 4'h0;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'h1;
  localparam logic [REG_AW-1:0] OFS_PTR   = 4'h2;
  localparam logic [REG_AW-1:0] OFS_DATA  = 4'h3;
  localparam logic [REG_AW-1:0] OFS_START = 4'h4;

  typedef enum logic [1:0] {
    GATE_SHUT  = 2'd0,
    GATE_ARMED = 2'd1,
    GATE_OPEN  = 2'd2
  } gate_t;
endpackage

// File: rtl/cfgk_key_fsm.sv
module cfgk_key_fsm
  import cfgk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'hC0,
  parameter logic [DATA_W-1:0] KEY_B = 8'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic              other_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  gate_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= GATE_SHUT;
    end else if (key_wr) begin
      case (st)
        GATE_SHUT:  st <= (wdata == KEY_A) ? GATE_ARMED : GATE_SHUT;
        GATE_ARMED: st <= (wdata == KEY_B) ? GATE_OPEN : GATE_SHUT;
        default:    st <= GATE_SHUT;
      endcase
    end else if (other_wr && st == GATE_ARMED) begin
      st <= GATE_SHUT;
    end
  end

  assign unlocked = (st == GATE_OPEN);

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr && unlocked) |=> !unlocked);
  // R2
  open_path_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && wdata == KEY_B));
endmodule

// File: rtl/cfgk_ptr_port.sv
module cfgk_ptr_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              allow,
  input  logic              ptr_wr,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= allow && dat_wr;
      if (allow && ptr_wr) begin
        ptr <= wdata;
      end else if (allow && dat_wr) begin
        ptr       <= ptr + 1'b1;
        mem_addr  <= ptr;
        mem_wdata <= wdata;
      end
    end
  end

  // R5
  we_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(allow));
  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ptr == DATA_W'(mem_addr + 1'b1)));
endmodule

// File: rtl/cfgk_idx_bank.sv
module cfgk_idx_bank #(
  parameter int DATA_W  = 8,
  parameter int N_START = 3,
  localparam int SEL_W  = (N_START > 1) ? $clog2(N_START) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]         wdata,
  output logic [N_START*DATA_W-1:0] idx_flat
);
  for (genvar g = 0; g < N_START; g++) begin : g_idx
    always_ff @(posedge clk) begin
      if (rst) begin
        idx_flat[g*DATA_W +: DATA_W] <= '0;
      end else if (we && sel == SEL_W'(g)) begin
        idx_flat[g*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cfgk_port.sv
module cfgk_port
  import cfgk_pkg::*;
#(
  parameter int N_START = 3,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [REG_AW-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      mem_we,
  output logic [DATA_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic [N_START*DATA_W-1:0] start_idx
);
  localparam int SEL_W = (N_START > 1) ? $clog2(N_START) : 1;

  logic                unlocked, viol;
  logic [REG_AW-1:0]   ofs;
  logic                in_idx, hit_key, hit_ptr, hit_dat, guarded, clr_wr;
  logic [SEL_W-1:0]    sel;
  logic [DATA_W-1:0]   ptr;

  assign ofs     = bus_addr - OFS_START;
  assign in_idx  = (bus_addr >= OFS_START) && (ofs < REG_AW'(N_START));
  assign sel     = ofs[SEL_W-1:0];
  assign hit_key = bus_wr && bus_addr == OFS_KEY;
  assign hit_ptr = bus_wr && bus_addr == OFS_PTR;
  assign hit_dat = bus_wr && bus_addr == OFS_DATA;
  assign guarded = hit_ptr || hit_dat || (bus_wr && in_idx);
  assign clr_wr  = bus_wr && bus_addr == OFS_STAT && bus_wdata[0];

  cfgk_key_fsm #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst(rst), .key_wr(hit_key),
    .other_wr(bus_wr && bus_addr != OFS_KEY),
    .wdata(bus_wdata), .unlocked(unlocked)
  );

  cfgk_ptr_port #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst), .allow(unlocked), .ptr_wr(hit_ptr),
    .dat_wr(hit_dat), .wdata(bus_wdata), .ptr(ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  cfgk_idx_bank #(.DATA_W(DATA_W), .N_START(N_START)) u_idx (
    .clk(clk), .rst(rst), .we(unlocked && bus_wr && in_idx),
    .sel(sel), .wdata(bus_wdata), .idx_flat(start_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      viol <= 1'b0;
    end else if (guarded && !unlocked) begin
      viol <= 1'b1;
    end else if (clr_wr) begin
      viol <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == OFS_KEY)       bus_rdata <= DATA_W'(unlocked);
      else if (bus_addr == OFS_STAT) bus_rdata <= DATA_W'(viol);
      else if (bus_addr == OFS_PTR)  bus_rdata <= ptr;
      else if (in_idx)               bus_rdata <= start_idx[sel*DATA_W +: DATA_W];
      else                           bus_rdata <= '0;
    end
  end

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(unlocked) |-> $stable(start_idx));
  // R6
  viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(viol && !clr_wr) |-> viol);
endmodule

// File: tb/test_cfgk_port.sv
module test_cfgk_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, mem_addr, mem_wdata;
  logic mem_we;
  logic [23:0] start_idx;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  cfgk_port i_cfgk_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .start_idx(start_idx)
  );

  // vector: {req[3:0], wr, addr[3:0], data[7:0], exp[7:0]}
  localparam int NV = 25;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  1'b0, 4'h0, 8'h00, 8'h00},  // R1 locked after reset
    {4'd2,  1'b1, 4'h0, 8'hC0, 8'h00},
    {4'd2,  1'b0, 4'h0, 8'h00, 8'h00},  // R2 armed reads 0
    {4'd2,  1'b1, 4'h0, 8'h0C, 8'h00},
    {4'd2,  1'b0, 4'h0, 8'h00, 8'h01},  // R2 open reads 1
    {4'd9,  1'b1, 4'h4, 8'h2B, 8'h00},
    {4'd9,  1'b1, 4'h5, 8'h2F, 8'h00},
    {4'd9,  1'b0, 4'h4, 8'h00, 8'h2B},  // R9
    {4'd9,  1'b0, 4'h5, 8'h00, 8'h2F},  // R9
    {4'd4,  1'b1, 4'h0, 8'h00, 8'h00},
    {4'd4,  1'b0, 4'h0, 8'h00, 8'h00},  // R4 relocked
    {4'd5,  1'b1, 4'h4, 8'h55, 8'h00},
    {4'd5,  1'b0, 4'h4, 8'h00, 8'h2B},  // R5 dropped
    {4'd6,  1'b0, 4'h1, 8'h00, 8'h01},  // R6 flag set
    {4'd6,  1'b1, 4'h1, 8'h01, 8'h00},
    {4'd6,  1'b0, 4'h1, 8'h00, 8'h00},  // R6 cleared
    {4'd3,  1'b1, 4'h0, 8'hC0, 8'h00},
    {4'd3,  1'b1, 4'h0, 8'hC0, 8'h00},
    {4'd3,  1'b1, 4'h0, 8'h0C, 8'h00},
    {4'd3,  1'b0, 4'h0, 8'h00, 8'h00},  // R3 repeated first key
    {4'd3,  1'b1, 4'h0, 8'hC0, 8'h00},
    {4'd3,  1'b1, 4'h1, 8'h00, 8'h00},
    {4'd3,  1'b1, 4'h0, 8'h0C, 8'h00},
    {4'd3,  1'b0, 4'h0, 8'h00, 8'h00},  // R3 interleaved write
    {4'd10, 1'b0, 4'hF, 8'h00, 8'h00}   // R10 unmapped
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    check(1, {31'd0, mem_we}, 32'd0);
    check(1, {8'd0, start_idx}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:16], v);
        check(int'(VEC[i][24:21]), {24'd0, v}, {24'd0, VEC[i][7:0]});
      end
    end
    // R7 indirect write timing
    wr(4'h0, 8'hC0); wr(4'h0, 8'h0C);
    wr(4'h2, 8'h10);
    wr(4'h3, 8'hAA);
    check(7, {15'd0, mem_we, mem_addr, mem_wdata}, {15'd0, 1'b1, 8'h10, 8'hAA});
    @(negedge clk);
    check(7, {31'd0, mem_we}, 32'd0);
    // R8 auto-increment
    for (int k = 1; k < 4; k++) begin
      wr(4'h3, 8'(k));
      check(8, {24'd0, mem_addr}, 32'h10 + k);
    end
    rd(4'h2, v);
    check(8, {24'd0, v}, 32'h14);
    wr(4'h2, 8'hFF);
    wr(4'h3, 8'h01);
    check(8, {24'd0, mem_addr}, 32'hFF);
    wr(4'h3, 8'h02);
    check(8, {24'd0, mem_addr}, 32'h00);
    // R9 output port
    check(9, {24'd0, start_idx[7:0]}, 32'h2B);
    // R4 nonzero key value while open relocks
    wr(4'h0, 8'h5A);
    rd(4'h0, v);
    check(4, {24'd0, v}, 32'd0);
    // R5 locked memory writes dropped
    wr(4'h3, 8'h77);
    check(5, {31'd0, mem_we}, 32'd0);
    wr(4'h2, 8'h40);
    rd(4'h2, v);
    check(5, {24'd0, v}, 32'h01);
    // R1 reset mid-run
    wr(4'h0, 8'hC0); wr(4'h0, 8'h0C);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(4'h0, v);
    check(1, {24'd0, v}, 32'd0);
    check(1, {8'd0, start_idx}, 32'd0);
    rd(4'h2, v);
    check(1, {24'd0, v}, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<5000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule